// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block sits between decode and issue in an out-of-order core. Each cycle it can take a group of four decoded instructions, every one naming one architectural destination and two architectural sources, and turn them into twelve physical register numbers: a freshly allocated destination and two source mappings per instruction. New destinations are drawn from a free list, which is kept as a FIFO of physical register numbers. Sources are read from the current architectural-to-physical map. A source that matches the destination of an earlier instruction in the same group takes that instruction's new physical register instead, so dependences inside the group are settled in the cycle the group is renamed.

For recovery after a misspeculation, a group can save a checkpoint of the map and of the free-list read pointer, together with the group's time stamp, into one of four slots. A restore input returns the map, the read pointer and the stamp counter to a chosen slot in one cycle. A release port returns a retired physical register to the free list. There are 32 architectural and 64 physical registers. Architectural register zero is never renamed.

Top module: `rn_rename4`

## Requirements
- R1: A group is accepted on a rising edge when `in_valid` and `in_ready` are both high. Its results appear on the outputs one cycle later with `out_valid` high for exactly one cycle per accepted group. Slot i of every flattened vector occupies bits [i*W +: W], with slot 0 the oldest instruction.
- R2: Each slot with a nonzero destination receives the next free-list entry, taken in slot order. After reset, architectural register i maps to physical register i, and the free list holds physical registers 32 to 63 in ascending order.
- R3: A source with no older same-group match reads the map as it stood before the group, including updates made by all earlier accepted groups.
- R4: A nonzero source that matches the destination of an older slot in the same group takes the new physical register of the nearest such older slot.
- R5: A slot whose destination is zero allocates nothing, reports destination 0 and leaves the map unchanged. Source register zero always reads physical register 0.
- R6: While the free list holds fewer than four entries, `in_ready` is low and a presented group is neither renamed nor allowed to change any state.
- R7: A release appends its physical register to the tail of the free list. It takes effect in the same cycle as an allocation.
- R8: A group accepted with `ckpt_take` high saves, into slot `ckpt_id`, the map including that group's updates, the free-list read pointer after its allocations, and its stamp.
- R9: `restore_en` restores the map, the read pointer and the stamp from slot `restore_id` in one cycle. In that cycle `in_ready` is low, so a group presented then is not accepted.
- R10: `out_stamp` is the group's time stamp. It counts accepted groups from 0 after reset. After a restore, the next group's stamp is the saved stamp plus one.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A group of four instructions is presented |
| in_ready | output | 1 | Group can be accepted this cycle |
| in_dst | input | 20 | Four architectural destinations, 5 bits each |
| in_src1 | input | 20 | Four first architectural sources |
| in_src2 | input | 20 | Four second architectural sources |
| ckpt_take | input | 1 | Save a checkpoint with this group |
| ckpt_id | input | 2 | Checkpoint slot to write |
| restore_en | input | 1 | Roll back to a checkpoint |
| restore_id | input | 2 | Checkpoint slot to restore |
| rel_en | input | 1 | Return a physical register to the free list |
| rel_preg | input | 6 | Physical register being returned |
| out_valid | output | 1 | Renamed group is on the outputs |
| out_pdst | output | 24 | Four physical destinations, 6 bits each |
| out_psrc1 | output | 24 | Four physical first sources |
| out_psrc2 | output | 24 | Four physical second sources |
| out_stamp | output | 8 | Time stamp of the renamed group |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a restore and a presented group. The bench raises `restore_en` while a group is held valid. It then judges that no result appears for that cycle, and that the group, accepted one cycle later, sees the restored map, the rolled-back free-list pointer and the restored stamp. The second pair is a release and a four-register allocation, run with the free list nearly empty. The bench checks that the released register is the next one handed out and that `in_ready` follows the combined count.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int RN_LANES   = 4;
    localparam int RN_ARCH    = 32;
    localparam int RN_PHYS    = 64;
    localparam int RN_CKPTS   = 4;
    localparam int RN_STAMP_W = 8;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter int NPHYS = rn_pkg::RN_PHYS,
    parameter int NARCH = rn_pkg::RN_ARCH,
    parameter int LANES = rn_pkg::RN_LANES,
    localparam int PW = $clog2(NPHYS),
    localparam int CW = PW + 1,
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NW-1:0]         pop_n,
    input  logic                  push_en,
    input  logic [PW-1:0]         push_preg,
    input  logic                  rest_en,
    input  logic [CW-1:0]         rest_head,
    output logic [LANES*PW-1:0]   peek,
    output logic [CW-1:0]         head_o,
    output logic [CW-1:0]         count_o
);
    typedef struct packed {
        logic [NPHYS-1:0][PW-1:0] mem;
        logic [CW-1:0]            head;
        logic [CW-1:0]            tail;
    } fl_t;

    fl_t st_d, st_q;

    function automatic fl_t fl_reset();
        fl_t r;
        r = '0;
        for (int k = 0; k < NPHYS - NARCH; k++) begin
            r.mem[k] = PW'(NARCH + k);
        end
        r.tail = CW'(NPHYS - NARCH);
        return r;
    endfunction

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            logic [CW-1:0] p;
            p = st_q.head + CW'(k);
            peek[k*PW +: PW] = st_q.mem[p[PW-1:0]];
        end
    end

    assign head_o  = st_q.head;
    assign count_o = st_q.tail - st_q.head;

    always_comb begin
        st_d = st_q;
        if (rest_en) begin
            st_d.head = rest_head;
        end else begin
            st_d.head = st_q.head + CW'(pop_n);
        end
        if (push_en) begin
            st_d.mem[st_q.tail[PW-1:0]] = push_preg;
            st_d.tail = st_q.tail + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= fl_reset();
        else        st_q <= st_d;
    end

    // R7: a release never lands on a full list
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> count_o < CW'(NPHYS));

    // R6: allocation only ever takes entries that are present
    a_r6_pop_covered: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_n != '0) |-> count_o >= CW'(pop_n));
endmodule

// File: rtl/rn_map.sv
module rn_map #(
    parameter int NARCH = rn_pkg::RN_ARCH,
    parameter int NPHYS = rn_pkg::RN_PHYS,
    parameter int LANES = rn_pkg::RN_LANES,
    parameter int NCKPT = rn_pkg::RN_CKPTS,
    parameter int SW    = rn_pkg::RN_STAMP_W,
    localparam int AW = $clog2(NARCH),
    localparam int PW = $clog2(NPHYS),
    localparam int CW = PW + 1,
    localparam int KW = (NCKPT > 1) ? $clog2(NCKPT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0]      wr_en,
    input  logic [LANES*AW-1:0]   wr_arch,
    input  logic [LANES*PW-1:0]   wr_preg,
    input  logic                  ck_take,
    input  logic [KW-1:0]         ck_id,
    input  logic [CW-1:0]         ck_head,
    input  logic [SW-1:0]         ck_stamp,
    input  logic                  rest_en,
    input  logic [KW-1:0]         rest_id,
    output logic [NARCH*PW-1:0]   map_o,
    output logic [CW-1:0]         rest_head,
    output logic [SW-1:0]         rest_stamp
);
    typedef logic [NARCH-1:0][PW-1:0] tbl_t;

    typedef struct packed {
        tbl_t                      map;
        logic [NCKPT-1:0][NARCH*PW-1:0] ck_map;
        logic [NCKPT-1:0][CW-1:0]  ck_head;
        logic [NCKPT-1:0][SW-1:0]  ck_stamp;
    } mp_t;

    mp_t st_d, st_q;

    function automatic mp_t mp_reset();
        mp_t r;
        r = '0;
        for (int i = 0; i < NARCH; i++) begin
            r.map[i] = PW'(i);
        end
        for (int c = 0; c < NCKPT; c++) begin
            r.ck_map[c] = r.map;
        end
        return r;
    endfunction

    assign map_o      = st_q.map;
    assign rest_head  = st_q.ck_head[rest_id];
    assign rest_stamp = st_q.ck_stamp[rest_id];

    always_comb begin
        st_d = st_q;
        if (rest_en) begin
            st_d.map = st_q.ck_map[rest_id];
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_en[l]) begin
                    st_d.map[wr_arch[l*AW +: AW]] = wr_preg[l*PW +: PW];
                end
            end
            if (ck_take) begin
                st_d.ck_map[ck_id]   = st_d.map;
                st_d.ck_head[ck_id]  = ck_head;
                st_d.ck_stamp[ck_id] = ck_stamp;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= mp_reset();
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_zero_chk
        // R5: architectural zero is never remapped
        a_r5_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[g] |-> wr_arch[g*AW +: AW] != '0);
    end
endmodule

// File: rtl/rn_group.sv
module rn_group #(
    parameter int NARCH = rn_pkg::RN_ARCH,
    parameter int NPHYS = rn_pkg::RN_PHYS,
    parameter int LANES = rn_pkg::RN_LANES,
    localparam int AW = $clog2(NARCH),
    localparam int PW = $clog2(NPHYS),
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic [LANES*AW-1:0]  lane_dst,
    input  logic [LANES*AW-1:0]  lane_s1,
    input  logic [LANES*AW-1:0]  lane_s2,
    input  logic [NARCH*PW-1:0]  map_i,
    input  logic [LANES*PW-1:0]  peek,
    output logic [LANES*PW-1:0]  pdst_o,
    output logic [LANES*PW-1:0]  ps1_o,
    output logic [LANES*PW-1:0]  ps2_o,
    output logic [LANES-1:0]     wr_en_o,
    output logic [NW-1:0]        alloc_o
);
    // source lookup with bypass from the nearest older slot of the group
    function automatic logic [PW-1:0] resolve(
        input logic [AW-1:0]       s,
        input int                  lane,
        input logic [LANES*AW-1:0] dsts,
        input logic [LANES*PW-1:0] pds,
        input logic [NARCH*PW-1:0] tbl
    );
        logic [PW-1:0] r;
        r = tbl[int'(s)*PW +: PW];
        for (int j = 0; j < LANES; j++) begin
            if (j < lane && s != '0 && dsts[j*AW +: AW] == s) begin
                r = pds[j*PW +: PW];
            end
        end
        return r;
    endfunction

    always_comb begin
        int k;
        k = 0;
        pdst_o  = '0;
        wr_en_o = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_dst[l*AW +: AW] != '0) begin
                pdst_o[l*PW +: PW] = peek[k*PW +: PW];
                wr_en_o[l] = 1'b1;
                k = k + 1;
            end
        end
        alloc_o = NW'(k);
        for (int l = 0; l < LANES; l++) begin
            ps1_o[l*PW +: PW] = resolve(lane_s1[l*AW +: AW], l, lane_dst, pdst_o, map_i);
            ps2_o[l*PW +: PW] = resolve(lane_s2[l*AW +: AW], l, lane_dst, pdst_o, map_i);
        end
    end
endmodule

// File: rtl/rn_rename4.sv
module rn_rename4 #(
    parameter int LANES = rn_pkg::RN_LANES,
    parameter int NARCH = rn_pkg::RN_ARCH,
    parameter int NPHYS = rn_pkg::RN_PHYS,
    parameter int NCKPT = rn_pkg::RN_CKPTS,
    parameter int SW    = rn_pkg::RN_STAMP_W,
    localparam int AW = $clog2(NARCH),
    localparam int PW = $clog2(NPHYS),
    localparam int CW = PW + 1,
    localparam int KW = (NCKPT > 1) ? $clog2(NCKPT) : 1,
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [LANES*AW-1:0]  in_dst,
    input  logic [LANES*AW-1:0]  in_src1,
    input  logic [LANES*AW-1:0]  in_src2,
    input  logic                 ckpt_take,
    input  logic [KW-1:0]        ckpt_id,
    input  logic                 restore_en,
    input  logic [KW-1:0]        restore_id,
    input  logic                 rel_en,
    input  logic [PW-1:0]        rel_preg,
    output logic                 out_valid,
    output logic [LANES*PW-1:0]  out_pdst,
    output logic [LANES*PW-1:0]  out_psrc1,
    output logic [LANES*PW-1:0]  out_psrc2,
    output logic [SW-1:0]        out_stamp
);
    typedef struct packed {
        logic                vld;
        logic [LANES*PW-1:0] pd;
        logic [LANES*PW-1:0] s1;
        logic [LANES*PW-1:0] s2;
        logic [SW-1:0]       ostamp;
        logic [SW-1:0]       stamp;
    } rn_t;

    rn_t st_d, st_q;

    logic [LANES*PW-1:0] peek, g_pd, g_s1, g_s2;
    logic [LANES-1:0]    g_wr;
    logic [NW-1:0]       g_alloc;
    logic [CW-1:0]       fl_head, fl_count, ck_rest_head;
    logic [SW-1:0]       ck_rest_stamp;
    logic [NARCH*PW-1:0] map_flat;
    logic                accept;

    assign in_ready = !restore_en && (fl_count >= CW'(LANES));
    assign accept   = in_valid && in_ready;

    rn_freelist #(.NPHYS(NPHYS), .NARCH(NARCH), .LANES(LANES)) u_fl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_n     (accept ? g_alloc : '0),
        .push_en   (rel_en),
        .push_preg (rel_preg),
        .rest_en   (restore_en),
        .rest_head (ck_rest_head),
        .peek      (peek),
        .head_o    (fl_head),
        .count_o   (fl_count)
    );

    rn_map #(.NARCH(NARCH), .NPHYS(NPHYS), .LANES(LANES), .NCKPT(NCKPT), .SW(SW)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (accept ? g_wr : '0),
        .wr_arch    (in_dst),
        .wr_preg    (g_pd),
        .ck_take    (accept && ckpt_take),
        .ck_id      (ckpt_id),
        .ck_head    (fl_head + CW'(g_alloc)),
        .ck_stamp   (st_q.stamp),
        .rest_en    (restore_en),
        .rest_id    (restore_id),
        .map_o      (map_flat),
        .rest_head  (ck_rest_head),
        .rest_stamp (ck_rest_stamp)
    );

    rn_group #(.NARCH(NARCH), .NPHYS(NPHYS), .LANES(LANES)) u_grp (
        .lane_dst (in_dst),
        .lane_s1  (in_src1),
        .lane_s2  (in_src2),
        .map_i    (map_flat),
        .peek     (peek),
        .pdst_o   (g_pd),
        .ps1_o    (g_s1),
        .ps2_o    (g_s2),
        .wr_en_o  (g_wr),
        .alloc_o  (g_alloc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = accept;
        if (accept) begin
            st_d.pd     = g_pd;
            st_d.s1     = g_s1;
            st_d.s2     = g_s2;
            st_d.ostamp = st_q.stamp;
            st_d.stamp  = st_q.stamp + SW'(1);
        end
        if (restore_en) begin
            st_d.stamp = ck_rest_stamp + SW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_pdst  = st_q.pd;
    assign out_psrc1 = st_q.s1;
    assign out_psrc2 = st_q.s2;
    assign out_stamp = st_q.ostamp;

    function automatic logic has_dup(input logic [LANES*PW-1:0] v);
        logic f;
        f = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            for (int j = 0; j < LANES; j++) begin
                if (i < j && v[i*PW +: PW] != '0 && v[i*PW +: PW] == v[j*PW +: PW]) f = 1'b1;
            end
        end
        return f;
    endfunction

    // R9: a restore cycle renames nothing
    a_r9_restore_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> !out_valid);

    // R6: a stalled group leaves no result
    a_r6_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> !out_valid);

    // R2: destinations of one group are distinct
    a_r2_unique_dst: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !has_dup(out_pdst));

    // R1: results last one cycle unless a new group was accepted
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);
endmodule

// File: tb/sim_rn_rename4.sv
module sim_rn_rename4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [19:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic        ckpt_take = 1'b0;
    logic [1:0]  ckpt_id = '0;
    logic        restore_en = 1'b0;
    logic [1:0]  restore_id = '0;
    logic        rel_en = 1'b0;
    logic [5:0]  rel_preg = '0;
    logic        out_valid;
    logic [23:0] out_pdst, out_psrc1, out_psrc2;
    logic [7:0]  out_stamp;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rn_rename4 u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .ckpt_take(ckpt_take), .ckpt_id(ckpt_id),
        .restore_en(restore_en), .restore_id(restore_id),
        .rel_en(rel_en), .rel_preg(rel_preg),
        .out_valid(out_valid), .out_pdst(out_pdst), .out_psrc1(out_psrc1),
        .out_psrc2(out_psrc2), .out_stamp(out_stamp)
    );

    // table: dst, src1, src2 per slot, and expected pdst, psrc1, psrc2
    localparam int TD [4][4] = '{'{1,2,3,4}, '{1,1,0,5}, '{0,0,0,0}, '{7,7,7,7}};
    localparam int T1 [4][4] = '{'{5,1,2,3}, '{1,1,1,5}, '{1,3,4,0}, '{7,7,7,7}};
    localparam int T2 [4][4] = '{'{6,0,1,9}, '{4,2,0,1}, '{5,2,6,31}, '{7,1,0,7}};
    localparam int XD [4][4] = '{'{32,33,34,35}, '{36,37,0,38}, '{0,0,0,0}, '{39,40,41,42}};
    localparam int X1 [4][4] = '{'{5,32,33,34}, '{32,36,37,5}, '{37,34,35,0}, '{7,39,40,41}};
    localparam int X2 [4][4] = '{'{6,0,32,9}, '{35,33,0,37}, '{38,33,6,31}, '{7,37,0,41}};

    function automatic logic [19:0] pa(input int a, b, c, d);
        return {5'(d), 5'(c), 5'(b), 5'(a)};
    endfunction
    function automatic logic [23:0] pp(input int a, b, c, d);
        return {6'(d), 6'(c), 6'(b), 6'(a)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic present(input logic [19:0] d, s1, s2);
        in_dst = d; in_src1 = s1; in_src2 = s2; in_valid = 1'b1;
    endtask

    // one group through: drive at a falling edge, sample at the next
    task automatic group(input logic [19:0] d, s1, s2, input bit ck, input int ckid);
        @(negedge clk);
        present(d, s1, s2);
        ckpt_take = ck; ckpt_id = 2'(ckid);
        @(negedge clk);
        in_valid = 1'b0; ckpt_take = 1'b0;
    endtask

    task automatic chk_out(input string req, input logic [23:0] pd, p1, p2, input int st);
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " pdst"}, 32'(out_pdst), 32'(pd));
        chk({req, " psrc1"}, 32'(out_psrc1), 32'(p1));
        chk({req, " psrc2"}, 32'(out_psrc2), 32'(p2));
        chk({req, " stamp"}, 32'(out_stamp), 32'(st));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R11 in_ready after reset", 32'(in_ready), 32'd1);

        // R1 R2 R3 R4 R5 R10: vector table from reset
        for (int v = 0; v < 4; v++) begin
            group(pa(TD[v][0], TD[v][1], TD[v][2], TD[v][3]),
                  pa(T1[v][0], T1[v][1], T1[v][2], T1[v][3]),
                  pa(T2[v][0], T2[v][1], T2[v][2], T2[v][3]), 1'b0, 0);
            chk_out("R2/R3/R4/R5/R10 table",
                    pp(XD[v][0], XD[v][1], XD[v][2], XD[v][3]),
                    pp(X1[v][0], X1[v][1], X1[v][2], X1[v][3]),
                    pp(X2[v][0], X2[v][1], X2[v][2], X2[v][3]), v);
        end
        @(negedge clk);
        chk("R1 single pulse", 32'(out_valid), 32'd0);

        // R8: checkpoint into slot 2 with group A
        group(pa(8,0,0,0), pa(0,0,0,0), pa(0,0,0,0), 1'b1, 2);
        chk_out("R8 group A", pp(43,0,0,0), pp(0,0,0,0), pp(0,0,0,0), 4);
        group(pa(8,9,0,0), pa(8,8,0,0), pa(0,9,0,0), 1'b0, 0);
        chk_out("R4 group B", pp(44,45,0,0), pp(43,44,0,0), pp(0,9,0,0), 5);

        // R9: restore and a group in the same cycle
        @(negedge clk);
        present(pa(10,0,0,0), pa(8,0,0,0), pa(9,0,0,0));
        restore_en = 1'b1; restore_id = 2'd2;
        #1;
        chk("R9 in_ready low during restore", 32'(in_ready), 32'd0);
        @(negedge clk);
        restore_en = 1'b0;
        chk("R9 no result from restore cycle", 32'(out_valid), 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        chk_out("R9/R10 group after restore", pp(44,0,0,0), pp(43,0,0,0), pp(9,0,0,0), 5);

        // drain free list to three entries
        for (int g = 0; g < 4; g++) begin
            group(pa(20,21,22,23), pa(0,0,0,0), pa(0,0,0,0), 1'b0, 0);
            chk("R2 drain pdst", 32'(out_pdst), 32'(pp(45+4*g, 46+4*g, 47+4*g, 48+4*g)));
        end
        // R6: stall with three entries left
        @(negedge clk);
        present(pa(20,0,0,0), pa(0,0,0,0), pa(0,0,0,0));
        #1;
        chk("R6 in_ready low with three free", 32'(in_ready), 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 stalled group has no result", 32'(out_valid), 32'd0);

        // R7: release one, then allocate with a release in the same cycle
        rel_en = 1'b1; rel_preg = 6'd1;
        @(negedge clk);
        rel_en = 1'b0;
        #1;
        chk("R7 release restores in_ready", 32'(in_ready), 32'd1);
        @(negedge clk);
        present(pa(24,25,26,27), pa(20,24,0,0), pa(21,0,0,0));
        rel_en = 1'b1; rel_preg = 6'd2;
        @(negedge clk);
        in_valid = 1'b0; rel_en = 1'b0;
        chk_out("R6/R7 group E", pp(61,62,63,1), pp(57,61,0,0), pp(58,0,0,0), 10);
        #1;
        chk("R6 in_ready low with one free", 32'(in_ready), 32'd0);
        for (int r = 0; r < 3; r++) begin
            @(negedge clk);
            rel_en = 1'b1; rel_preg = (r == 2) ? 6'd6 : 6'(3 + r);
        end
        @(negedge clk);
        rel_en = 1'b0;
        #1;
        chk("R7 in_ready back with four free", 32'(in_ready), 32'd1);
        group(pa(1,0,0,0), pa(24,0,0,0), pa(27,0,0,0), 1'b0, 0);
        chk_out("R7 released register reused", pp(2,0,0,0), pp(61,0,0,0), pp(1,0,0,0), 11);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule